// File: doc/BRIEF.md
# Card Information Tuple Chain Scanner

This block walks the linked list of tuples held in a card's information structure and looks for the first tuple whose type code equals a requested value. Each tuple has a type byte, then a link byte, then as many body bytes as the link byte says. The block reads the structure one byte at a time through a simple memory read port. It follows the links from one tuple to the next until it finds a match or runs into a stop condition. On a match it streams out the matching tuple's body bytes and then reports how many it delivered.

A scan starts with a one-cycle start pulse. The pulse carries the wanted type code, a cap on the number of body bytes to deliver, and a flag that selects attribute space. In attribute space only even addresses hold data, so logical byte n sits at address 2n. A scan stops without a match on any of these: a terminator type byte, a terminator link byte, reading past the end of the 8 KB logical region, or reaching the limit of 1000 examined tuples. Every scan ends with a one-cycle done pulse. The block does not interpret the body bytes.

Top module: `cis_tuple_walker`

## Requirements
- R1: The first tuple of type code T sits at logical position 0. The tuple after a tuple at position p sits at p + 2 + L, where L is the byte at p + 1. A scan for code C reports found for the first tuple in that chain whose type equals C, and streams its body bytes (positions p + 2 onward) in order on `out_byte`, each with a one-cycle `out_valid`.
- R2: On a match, exactly min(L, `max_len`) body bytes are delivered, and `count` then equals that number. A `max_len` of 0 gives found with count 0 and no bytes.
- R3: A type byte of 0xFF ends the scan as not-found, with `count` equal to 0.
- R4: A link byte of 0xFF ends the scan as not-found, even when the type byte matched.
- R5: With `attr_space` set, logical byte n is read from `mem_addr` 2n, and no odd address is ever read. With it clear, logical byte n is read from address n.
- R6: No logical position at or above 8192 is read. If a type or link byte would fall there, the result is not-found. If a body byte would fall there, the result is found, with the bytes delivered so far.
- R7: At most 1000 tuples (indices 0 to 999) are examined. A match at tuple index 999 is found, and a match at index 1000 is not-found.
- R8: Each scan raises `done` for exactly one cycle. `found` and `not_found` are never high together, and both hold their values, along with `count`, until the next accepted start.
- R9: A `start` pulse while `busy` is high is ignored: the running scan keeps its code, finishes with its own result, and gives a single done pulse.
- R10: After reset, `busy`, `done`, `found`, `not_found`, `out_valid` and `mem_rd` are all low.
- R11: `mem_rd` is a one-cycle strobe with `mem_addr`. The data for it is taken from `mem_rdata` on the next cycle, and a new read is never issued in the cycle right after one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle scan request (ignored while busy) |
| want_code | input | 8 | Tuple type code to search for |
| max_len | input | LEN_W | Largest number of body bytes to deliver |
| attr_space | input | 1 | 1 selects attribute space (byte n at address 2n) |
| busy | output | 1 | A scan is in progress |
| mem_rd | output | 1 | Read strobe to the structure memory |
| mem_addr | output | ADDR_W | Read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the strobe |
| out_byte | output | 8 | Delivered body byte |
| out_valid | output | 1 | Strobe for out_byte |
| done | output | 1 | One-cycle end-of-scan pulse |
| found | output | 1 | Last scan matched |
| not_found | output | 1 | Last scan ended without a match |
| count | output | LEN_W | Number of body bytes delivered by the last scan |

## Verification
The search is tried against several chain shapes:
- A short chain with two tuples of the same code tells first-match apart from a later match, and a zero cap tells "cap honoured" apart from "link honoured".
- The same chain laid out in attribute space, with 0xFF at every odd address, shows whether the address stride is right.
- Chains built from long jumps that end exactly at the 8 KB boundary, and a chain of 1000 plain tuples with a match just before or just after the limit, tell each stop condition apart from the others.
- A start pulse injected mid-scan with a different code shows whether the block restarts or keeps its scan.

// File: rtl/cisw_pkg.sv
package cisw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_TAKE
  } walk_state_t;

  typedef enum logic [1:0] {
    FLD_TYPE,
    FLD_LINK,
    FLD_BODY
  } field_t;

  localparam logic [7:0] CHAIN_END = 8'hFF;

endpackage

// File: rtl/cisw_port_drv.sv
module cisw_port_drv #(
  parameter int POS_W      = 14,
  parameter int ATTR_SHIFT = 1,
  localparam int ADDR_W    = POS_W + ATTR_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [POS_W-1:0]  pos,
  input  logic              attr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr
);

  logic [ADDR_W-1:0] addr_c;

  // Scale the logical position by the stride of the selected space.
  always_comb begin
    if (attr) addr_c = ADDR_W'(pos) << ATTR_SHIFT;
    else      addr_c = ADDR_W'(pos);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd   <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_rd <= req;
      if (req) mem_addr <= addr_c;
    end
  end

endmodule

// File: rtl/cisw_tuple_ctr.sv
module cisw_tuple_ctr #(
  parameter int MAX_TUPLES = 1000,
  localparam int TW        = $clog2(MAX_TUPLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic at_limit
);

  logic [TW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst || clear) seen <= '0;
    else if (inc && !at_limit) seen <= seen + TW'(1);
  end

  assign at_limit = (seen == TW'(MAX_TUPLES));

endmodule

// File: rtl/cisw_result_reg.sv
module cisw_result_reg #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             byte_we,
  input  logic [7:0]       byte_in,
  input  logic             fin,
  input  logic             fin_found,
  input  logic [LEN_W-1:0] fin_count,
  output logic [7:0]       out_byte,
  output logic             out_valid,
  output logic             done,
  output logic             found,
  output logic             not_found,
  output logic [LEN_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_byte  <= '0;
      out_valid <= 1'b0;
      done      <= 1'b0;
      found     <= 1'b0;
      not_found <= 1'b0;
      count     <= '0;
    end else begin
      out_valid <= byte_we;
      done      <= fin;
      if (byte_we) out_byte <= byte_in;
      if (clear) begin
        found     <= 1'b0;
        not_found <= 1'b0;
        count     <= '0;
      end else if (fin) begin
        found     <= fin_found;
        not_found <= !fin_found;
        count     <= fin_found ? fin_count : '0;
      end
    end
  end

endmodule

// File: rtl/cis_tuple_walker.sv
module cis_tuple_walker #(
  parameter int REGION_BYTES = 8192,
  parameter int MAX_TUPLES   = 1000,
  parameter int LEN_W        = 9,
  parameter int ATTR_SHIFT   = 1,
  localparam int POS_W       = $clog2(REGION_BYTES) + 1,
  localparam int ADDR_W      = POS_W + ATTR_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        want_code,
  input  logic [LEN_W-1:0]  max_len,
  input  logic              attr_space,
  output logic              busy,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        out_byte,
  output logic              out_valid,
  output logic              done,
  output logic              found,
  output logic              not_found,
  output logic [LEN_W-1:0]  count
);

  import cisw_pkg::*;

  walk_state_t      state;
  field_t           field;
  logic [POS_W-1:0] pos;
  logic [7:0]       want_q;
  logic             attr_q;
  logic [LEN_W-1:0] maxl_q;
  logic [LEN_W-1:0] lim_q;
  logic [LEN_W-1:0] deliv_q;
  logic             hit_q;

  logic start_ok, past_end, tup_at_limit;
  logic fin, fin_found, rd_req, tup_inc, body_we;
  logic [LEN_W-1:0] link_len;

  assign start_ok = start && (state == ST_IDLE);
  assign past_end = (pos >= POS_W'(REGION_BYTES));
  assign busy     = (state != ST_IDLE);
  assign link_len = LEN_W'(mem_rdata);
  assign body_we  = (state == ST_TAKE) && (field == FLD_BODY);
  assign tup_inc  = (state == ST_TAKE) && (field == FLD_LINK) &&
                    (mem_rdata != CHAIN_END) && !hit_q;

  // Stop decisions: bounds before each read, terminators after each read.
  always_comb begin
    fin       = 1'b0;
    fin_found = 1'b0;
    rd_req    = 1'b0;
    if (state == ST_ISSUE) begin
      unique case (field)
        FLD_TYPE: begin
          if (tup_at_limit || past_end) fin = 1'b1;
          else rd_req = 1'b1;
        end
        FLD_LINK: begin
          if (past_end) fin = 1'b1;
          else rd_req = 1'b1;
        end
        default: begin
          if ((deliv_q == lim_q) || past_end) begin
            fin       = 1'b1;
            fin_found = 1'b1;
          end else begin
            rd_req = 1'b1;
          end
        end
      endcase
    end else if (state == ST_TAKE) begin
      if ((field != FLD_BODY) && (mem_rdata == CHAIN_END)) fin = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      field   <= FLD_TYPE;
      pos     <= '0;
      want_q  <= '0;
      attr_q  <= 1'b0;
      maxl_q  <= '0;
      lim_q   <= '0;
      deliv_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_ok) begin
            want_q  <= want_code;
            attr_q  <= attr_space;
            maxl_q  <= max_len;
            pos     <= '0;
            field   <= FLD_TYPE;
            deliv_q <= '0;
            hit_q   <= 1'b0;
            state   <= ST_ISSUE;
          end
        end
        ST_ISSUE: state <= fin ? ST_IDLE : ST_WAIT;
        ST_WAIT:  state <= ST_TAKE;
        default: begin
          if (fin) begin
            state <= ST_IDLE;
          end else begin
            state <= ST_ISSUE;
            unique case (field)
              FLD_TYPE: begin
                hit_q <= (mem_rdata == want_q);
                pos   <= pos + POS_W'(1);
                field <= FLD_LINK;
              end
              FLD_LINK: begin
                if (hit_q) begin
                  lim_q <= (link_len < maxl_q) ? link_len : maxl_q;
                  pos   <= pos + POS_W'(1);
                  field <= FLD_BODY;
                end else begin
                  pos   <= pos + POS_W'(1) + POS_W'(mem_rdata);
                  field <= FLD_TYPE;
                end
              end
              default: begin
                deliv_q <= deliv_q + LEN_W'(1);
                pos     <= pos + POS_W'(1);
              end
            endcase
          end
        end
      endcase
    end
  end

  cisw_port_drv #(
    .POS_W      (POS_W),
    .ATTR_SHIFT (ATTR_SHIFT)
  ) port_i (
    .clk      (clk),
    .rst      (rst),
    .req      (rd_req),
    .pos      (pos),
    .attr     (attr_q),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr)
  );

  cisw_tuple_ctr #(
    .MAX_TUPLES (MAX_TUPLES)
  ) tup_i (
    .clk      (clk),
    .rst      (rst),
    .clear    (start_ok),
    .inc      (tup_inc),
    .at_limit (tup_at_limit)
  );

  cisw_result_reg #(
    .LEN_W (LEN_W)
  ) res_i (
    .clk       (clk),
    .rst       (rst),
    .clear     (start_ok),
    .byte_we   (body_we),
    .byte_in   (mem_rdata),
    .fin       (fin),
    .fin_found (fin_found),
    .fin_count (deliv_q),
    .out_byte  (out_byte),
    .out_valid (out_valid),
    .done      (done),
    .found     (found),
    .not_found (not_found),
    .count     (count)
  );

endmodule

// File: rtl/cisw_chk.sv
module cisw_chk #(
  parameter int REGION_BYTES = 8192,
  parameter int LEN_W        = 9,
  parameter int ADDR_W       = 15,
  parameter int ATTR_SHIFT   = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              attr_q,
  input logic [LEN_W-1:0]  maxl_q,
  input logic              out_valid,
  input logic              done,
  input logic              found,
  input logic              not_found,
  input logic [LEN_W-1:0]  count
);

  logic [ADDR_W-1:0] logical_pos;
  assign logical_pos = attr_q ? (mem_addr >> ATTR_SHIFT) : mem_addr;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  result_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(found && not_found));

  // R5
  attr_even_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && attr_q) |-> (mem_addr[0] == 1'b0));

  // R6
  region_bound_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (logical_pos < ADDR_W'(REGION_BYTES)));

  // R11
  rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R3
  miss_count_chk: assert property (@(posedge clk) disable iff (rst)
    not_found |-> (count == '0));

  // R2
  count_cap_chk: assert property (@(posedge clk) disable iff (rst)
    found |-> (count <= maxl_q));

  // R1
  stream_busy_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);

endmodule

bind cis_tuple_walker cisw_chk #(
  .REGION_BYTES (REGION_BYTES),
  .LEN_W        (LEN_W),
  .ADDR_W       (ADDR_W),
  .ATTR_SHIFT   (ATTR_SHIFT)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .mem_rd    (mem_rd),
  .mem_addr  (mem_addr),
  .attr_q    (attr_q),
  .maxl_q    (maxl_q),
  .out_valid (out_valid),
  .done      (done),
  .found     (found),
  .not_found (not_found),
  .count     (count)
);

// File: tb/cis_tuple_walker_tb_top.sv
module cis_tuple_walker_tb_top;

  localparam int LEN_W  = 9;
  localparam int ADDR_W = 15;

  logic              clk = 1'b0;
  logic              rst;
  logic              start;
  logic [7:0]        want_code;
  logic [LEN_W-1:0]  max_len;
  logic              attr_space;
  logic              busy;
  logic              mem_rd;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_rdata;
  logic [7:0]        out_byte;
  logic              out_valid;
  logic              done;
  logic              found;
  logic              not_found;
  logic [LEN_W-1:0]  count;

  always #5 clk = ~clk;

  cis_tuple_walker dut_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .want_code  (want_code),
    .max_len    (max_len),
    .attr_space (attr_space),
    .busy       (busy),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .out_byte   (out_byte),
    .out_valid  (out_valid),
    .done       (done),
    .found      (found),
    .not_found  (not_found),
    .count      (count)
  );

  // Sparse memory model, one-cycle read latency, unwritten bytes read as 0.
  logic [7:0] mem [int];
  int odd_reads = 0;
  bit fill_attr = 1'b0;

  function automatic logic [7:0] mem_at(int a);
    if (mem.exists(a)) return mem[a];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem_at(int'(mem_addr));
      if (mem_addr[0]) odd_reads <= odd_reads + 1;
    end
  end

  task automatic put(int p, logic [7:0] v);
    if (fill_attr) begin
      mem[2*p]     = v;
      mem[2*p + 1] = 8'hFF;
    end else begin
      mem[p] = v;
    end
  endtask

  int nchk = 0;
  int nerr = 0;

  task automatic chk(string req, bit ok, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Results of the most recent scan
  logic [7:0] got [0:511];
  int got_n;
  int done_cnt;
  bit r_found, r_miss;
  int r_count;

  task automatic run(logic [7:0] code, int ml, bit attr, int poke);
    int cyc = 0;
    bit fin = 1'b0;
    got_n    = 0;
    done_cnt = 0;
    @(negedge clk);
    start = 1'b1; want_code = code; max_len = LEN_W'(ml); attr_space = attr;
    @(negedge clk);
    start = 1'b0; want_code = 8'h00; max_len = '0; attr_space = 1'b0;
    while (!fin && cyc < 60000) begin
      if (cyc == poke) begin
        start = 1'b1; want_code = 8'h01; max_len = LEN_W'(1); attr_space = 1'b0;
      end else begin
        start = 1'b0;
      end
      if (out_valid && got_n < 512) begin
        got[got_n] = out_byte;
        got_n++;
      end
      if (done) begin
        done_cnt++;
        fin = 1'b1;
      end
      if (!fin) @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk("R8 scan ends", fin, int'(fin), 1);
    r_found = found;
    r_miss  = not_found;
    r_count = int'(count);
    @(negedge clk);
    chk("R8 done one cycle", !done && !busy, int'(done), 0);
    chk("R8 exclusive", !(found && not_found), int'(found), int'(!not_found));
  endtask

  task automatic expect_hit(string req, int n, logic [7:0] b0, logic [7:0] b1,
                            logic [7:0] b2, logic [7:0] b3);
    logic [7:0] e [0:3];
    e[0] = b0; e[1] = b1; e[2] = b2; e[3] = b3;
    chk({req, " found"}, r_found && !r_miss, int'(r_found), 1);
    chk({req, " count"}, r_count == n, r_count, n);
    chk({req, " bytes delivered"}, got_n == n, got_n, n);
    for (int i = 0; i < n && i < 4 && i < got_n; i++)
      chk({req, " byte"}, got[i] == e[i], int'(got[i]), int'(e[i]));
  endtask

  task automatic expect_miss(string req);
    chk({req, " not found"}, r_miss && !r_found, int'(r_miss), 1);
    chk({req, " count zero"}, r_count == 0, r_count, 0);
    chk({req, " no bytes"}, got_n == 0, got_n, 0);
  endtask

  task automatic load_basic();
    mem.delete();
    put(0, 8'h01); put(1, 8'd3); put(2, 8'hA0); put(3, 8'hA1); put(4, 8'hA2);
    put(5, 8'h15); put(6, 8'd4); put(7, 8'h11); put(8, 8'h22); put(9, 8'h33);
    put(10, 8'h44);
    put(11, 8'h15); put(12, 8'd2); put(13, 8'h55); put(14, 8'h66);
    put(15, 8'hFF);
  endtask

  task automatic t_reset();
    chk("R10 busy", !busy, int'(busy), 0);
    chk("R10 done", !done, int'(done), 0);
    chk("R10 found", !found && !not_found, int'(found), 0);
    chk("R10 out_valid", !out_valid, int'(out_valid), 0);
    chk("R10 mem_rd", !mem_rd, int'(mem_rd), 0);
  endtask

  task automatic t_basic();
    fill_attr = 1'b0;
    load_basic();
    run(8'h15, 16, 1'b0, -1);
    expect_hit("R1 first match", 4, 8'h11, 8'h22, 8'h33, 8'h44);
    run(8'h01, 16, 1'b0, -1);
    expect_hit("R1 head tuple", 3, 8'hA0, 8'hA1, 8'hA2, 8'h00);
    repeat (5) @(negedge clk);
    chk("R8 result held", found && count == LEN_W'(3), int'(count), 3);
  endtask

  task automatic t_cap();
    fill_attr = 1'b0;
    load_basic();
    run(8'h15, 2, 1'b0, -1);
    expect_hit("R2 capped", 2, 8'h11, 8'h22, 8'h00, 8'h00);
    run(8'h15, 0, 1'b0, -1);
    expect_hit("R2 zero cap", 0, 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_type_end();
    fill_attr = 1'b0;
    load_basic();
    run(8'h20, 16, 1'b0, -1);
    expect_miss("R3 type end");
  endtask

  task automatic t_link_end();
    fill_attr = 1'b0;
    load_basic();
    put(15, 8'h30); put(16, 8'hFF);
    put(17, 8'h30); put(18, 8'd1); put(19, 8'h99);
    run(8'h30, 16, 1'b0, -1);
    expect_miss("R4 link end");
  endtask

  task automatic t_attr();
    fill_attr = 1'b1;
    load_basic();
    odd_reads = 0;
    run(8'h15, 16, 1'b1, -1);
    expect_hit("R5 attribute space", 4, 8'h11, 8'h22, 8'h33, 8'h44);
    chk("R5 no odd reads", odd_reads == 0, odd_reads, 0);
    fill_attr = 1'b0;
  endtask

  task automatic load_jumps(int last_link);
    mem.delete();
    for (int k = 0; k < 31; k++) begin
      put(256*k, 8'h02); put(256*k + 1, 8'd254);
    end
    put(7936, 8'h02); put(7937, 8'(last_link));
  endtask

  task automatic t_region();
    fill_attr = 1'b0;
    load_jumps(250);
    put(8188, 8'h44); put(8189, 8'd10);
    put(8190, 8'hA1); put(8191, 8'hA2); put(8192, 8'hA3);
    run(8'h44, 20, 1'b0, -1);
    expect_hit("R6 body cut at region end", 2, 8'hA1, 8'hA2, 8'h00, 8'h00);
    load_jumps(253);
    put(8191, 8'h44); put(8192, 8'h00);
    run(8'h44, 20, 1'b0, -1);
    expect_miss("R6 link past region end");
  endtask

  task automatic t_limit();
    fill_attr = 1'b0;
    mem.delete();
    for (int k = 0; k < 1000; k++) put(2*k, 8'h03);
    put(2000, 8'h05); put(2001, 8'd1); put(2002, 8'h77);
    run(8'h05, 8, 1'b0, -1);
    expect_miss("R7 match at tuple 1000");
    put(1998, 8'h05); put(1999, 8'd1); put(2000, 8'h77);
    run(8'h05, 8, 1'b0, -1);
    expect_hit("R7 match at tuple 999", 1, 8'h77, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_busy_start();
    fill_attr = 1'b0;
    load_basic();
    run(8'h15, 16, 1'b0, 3);
    expect_hit("R9 start while busy", 4, 8'h11, 8'h22, 8'h33, 8'h44);
    chk("R9 single done", done_cnt == 1, done_cnt, 1);
    repeat (3) @(negedge clk);
    chk("R9 no restart", !busy, int'(busy), 0);
  endtask

  task automatic t_strobe();
    int rds = 0;
    int back = 0;
    bit prev = 1'b0;
    fill_attr = 1'b0;
    load_basic();
    @(negedge clk);
    start = 1'b1; want_code = 8'h01; max_len = LEN_W'(0); attr_space = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (mem_rd) rds++;
      if (mem_rd && prev) back++;
      prev = mem_rd;
      @(negedge clk);
    end
    chk("R11 two reads for type and link", rds == 2, rds, 2);
    chk("R11 no back-to-back reads", back == 0, back, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; want_code = '0; max_len = '0; attr_space = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_cap();
    t_type_end();
    t_link_end();
    t_attr();
    t_region();
    t_limit();
    t_busy_start();
    t_strobe();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule